// File: doc/BRIEF.md
# Freezable Performance Counters

This block is a small performance monitor with six 32-bit event counters. It has a 64-bit control register holding the freeze bits and a 64-bit event-select register. All of them are reached through one synchronous register port: a write strobe, an address, write data and combinational read data. On each clock the block sees two inputs: a cycle tick and an instruction-retired pulse. Counters 1 to 4 each take an 8-bit event code from the select register. Counter 5 is fixed to retired instructions and counter 6 is fixed to cycles.

Counting is gated by a global freeze bit and by two group freeze bits, one for counters 1 to 4 and one for counters 5 and 6. A counter keeps two values. The committed value is what a read returns. The pending value is what it has gathered during the current counting session. Pending counts move into the committed value only when a control write freezes the counter. So a read while the block is running returns the value the counter held when the session began. Software clears the global freeze bit to open a session and sets it again to see the results.

Top module: `frz_perf_mon`

## Requirements
- R1: After reset the control register reads 0x0000_0000_8000_0000 (global freeze, bit 31, set), the select register and all counters read 0, and no counter moves while the pulse inputs are active.
- R2: Address 0 is the control register, address 1 the event-select register, and addresses 2 to 7 are counters 1 to 6, read with the upper 32 bits zero. Any other address reads 0 and a write to it changes nothing.
- R3: Counter 5 counts retired-instruction pulses and counter 6 counts cycle ticks, whatever the select register holds.
- R4: The 8-bit event codes for counters 1, 2, 3 and 4 sit in select bits 31:24, 23:16, 15:8 and 7:0 in that order. In each of these counters, code 0x02 counts instruction pulses and code 0x1E counts cycle ticks.
- R5: Code 0xF0 counts cycles and code 0xFE counts instructions only in counter 1. In counters 2 to 4 these codes count nothing, and every other code counts nothing in any counter.
- R6: A counter advances only while control bit 31 is 0 and its group bit is 0. The group bit is bit 5 for counters 1 to 4 and bit 4 for counters 5 and 6.
- R7: While control bit 31 is 0, a counter read returns the value from the start of the session. A control write that sets bit 31 commits every pending count, including any event in the cycle of that write. The new total is readable from the next cycle.
- R8: When one control write sets bit 31 and a group bit together, the activity and commit decision uses the control value from before the write, so that group's counts are still committed.
- R9: While bit 31 stays 0, a write that changes a group bit commits that group's pending counts. The group then keeps counting or stops on its own, independently of the other group.
- R10: A write that clears bit 31 opens a session with an empty pending count. Counts gathered afterwards add to the committed values.
- R11: Every control bit is stored and read back. Bits 19:18, like all bits other than 31, 5 and 4, have no effect on counting.
- R12: Counters wrap modulo 2^32 and give no overflow indication.
- R13: A write to a counter loads its committed value and discards its pending count in the same clock. An event in that same cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Combinational read data for reg_addr |
| cyc_tick | input | 1 | One processor cycle elapsed |
| inst_ret | input | 1 | One instruction completed |

## Verification
Two things can land in the same clock: a counting event and the control or counter write that ends or reshapes a session. The bench provokes this by sending cycle ticks and instruction pulses in exactly the cycles of freeze, group-change, combined global-and-group and counter-load writes. A behavioural model decides, from the control value before the write, whether that last event belongs to the committed total or is dropped. Every cycle the read data is compared with that model, at rotating addresses, so a commit taken one cycle early or late, or one based on the new control value, shows up in the next counter read.

// File: rtl/pmon_pkg.sv
package pmon_pkg;
  localparam int NUM_CNT     = 6;
  localparam int GRP_A_SIZE  = 4;
  localparam int FRZ_ALL_BIT = 31;
  localparam int FRZ_A_BIT   = 5;
  localparam int FRZ_B_BIT   = 4;
  localparam int ADDR_CTL    = 0;
  localparam int ADDR_SEL    = 1;
  localparam int ADDR_CNT0   = 2;
  localparam int CODE_W      = 8;
  localparam logic [63:0] CTL_RESET = 64'h0000_0000_8000_0000;

  typedef enum logic [1:0] {EV_NONE, EV_CYC, EV_INST} ev_e;

  // Event decode for counter index idx (0-based).
  function automatic ev_e ev_decode(input int idx, input logic [63:0] sel);
    logic [CODE_W-1:0] code;
    ev_e r;
    code = sel[(GRP_A_SIZE-1-idx)*CODE_W +: CODE_W];
    r = EV_NONE;
    if (idx == GRP_A_SIZE) r = EV_INST;
    else if (idx == GRP_A_SIZE+1) r = EV_CYC;
    else begin
      case (code)
        8'h02: r = EV_INST;
        8'h1E: r = EV_CYC;
        8'hF0: r = (idx == 0) ? EV_CYC  : EV_NONE;
        8'hFE: r = (idx == 0) ? EV_INST : EV_NONE;
        default: r = EV_NONE;
      endcase
    end
    return r;
  endfunction

  function automatic logic grp_frozen(input int idx, input logic [63:0] ctl);
    return (idx < GRP_A_SIZE) ? ctl[FRZ_A_BIT] : ctl[FRZ_B_BIT];
  endfunction
endpackage

// File: rtl/pmon_ctrl.sv
module pmon_ctrl
  import pmon_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_we,
  input  logic          sel_we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] ctl_q,
  output logic [DW-1:0] sel_q,
  output logic          start_sess,
  output logic [NUM_CNT-1:0] commit_vec
);
  logic old_run, new_run;

  assign old_run    = ~ctl_q[FRZ_ALL_BIT];
  assign new_run    = ~wdata[FRZ_ALL_BIT];
  assign start_sess = ctl_we & ~old_run & new_run;

  // Decisions use the control value held before the write.
  always_comb begin
    for (int i = 0; i < NUM_CNT; i++) begin
      commit_vec[i] = ctl_we & old_run &
                      (~new_run | (grp_frozen(i, ctl_q) != grp_frozen(i, wdata)));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= CTL_RESET;
      sel_q <= '0;
    end else begin
      if (ctl_we) ctl_q <= wdata;
      if (sel_we) sel_q <= wdata;
    end
  end
endmodule

// File: rtl/pmon_counter.sv
module pmon_counter
  import pmon_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ev_e           ev,
  input  logic          run_en,
  input  logic          cyc_tick,
  input  logic          inst_ret,
  input  logic          commit,
  input  logic          clear_pend,
  input  logic          ld_we,
  input  logic [CW-1:0] ld_data,
  output logic [CW-1:0] value,
  output logic [CW-1:0] pending,
  output logic          inc
);
  logic [CW-1:0] pend_sum;

  assign inc = run_en & (((ev == EV_CYC) & cyc_tick) | ((ev == EV_INST) & inst_ret));
  assign pend_sum = pending + CW'(inc);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      value   <= '0;
      pending <= '0;
    end else if (ld_we) begin
      value   <= ld_data;
      pending <= '0;
    end else if (commit) begin
      value   <= value + pend_sum;
      pending <= '0;
    end else if (clear_pend) begin
      pending <= '0;
    end else begin
      pending <= pend_sum;
    end
  end
endmodule

// File: rtl/frz_perf_mon.sv
module frz_perf_mon
  import pmon_pkg::*;
#(
  parameter int CW = 32,
  parameter int DW = 64,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          cyc_tick,
  input  logic          inst_ret
);
  localparam int FLAT_W = NUM_CNT * CW;

  logic [DW-1:0]      ctl_q, sel_q;
  logic               start_sess;
  logic [NUM_CNT-1:0] commit_vec, inc_vec;
  logic [CW-1:0]      cnt_val [NUM_CNT];
  logic [CW-1:0]      cnt_pnd [NUM_CNT];
  logic [FLAT_W-1:0]  val_flat, pend_flat;
  logic               ctl_we, sel_we;

  assign ctl_we = reg_we & (reg_addr == AW'(ADDR_CTL));
  assign sel_we = reg_we & (reg_addr == AW'(ADDR_SEL));

  pmon_ctrl #(.DW(DW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .sel_we(sel_we),
    .wdata(reg_wdata), .ctl_q(ctl_q), .sel_q(sel_q),
    .start_sess(start_sess), .commit_vec(commit_vec)
  );

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    ev_e  ev_i;
    logic run_i, ld_i;
    assign ev_i  = ev_decode(i, sel_q);
    assign run_i = ~ctl_q[FRZ_ALL_BIT] & ~grp_frozen(i, ctl_q);
    assign ld_i  = reg_we & (reg_addr == AW'(ADDR_CNT0 + i));

    pmon_counter #(.CW(CW)) u_cnt (
      .clk(clk), .rst_n(rst_n), .ev(ev_i), .run_en(run_i),
      .cyc_tick(cyc_tick), .inst_ret(inst_ret),
      .commit(commit_vec[i]), .clear_pend(start_sess),
      .ld_we(ld_i), .ld_data(reg_wdata[CW-1:0]),
      .value(cnt_val[i]), .pending(cnt_pnd[i]), .inc(inc_vec[i])
    );

    assign val_flat[i*CW +: CW]  = cnt_val[i];
    assign pend_flat[i*CW +: CW] = cnt_pnd[i];
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == AW'(ADDR_CTL)) reg_rdata = ctl_q;
    if (reg_addr == AW'(ADDR_SEL)) reg_rdata = sel_q;
    for (int i = 0; i < NUM_CNT; i++) begin
      if (reg_addr == AW'(ADDR_CNT0 + i)) reg_rdata = DW'(cnt_val[i]);
    end
  end
endmodule

// File: rtl/pmon_chk.sv
module pmon_chk #(
  parameter int NUM = 6,
  parameter int FW  = 192
) (
  input logic           clk,
  input logic           rst_n,
  input logic           reg_we,
  input logic           cyc_tick,
  input logic           inst_ret,
  input logic           frz_all,
  input logic [7:0]     code2,
  input logic           start_sess,
  input logic [NUM-1:0] inc_vec,
  input logic [FW-1:0]  val_flat,
  input logic [FW-1:0]  pend_flat
);
  // R6
  frozen_no_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frz_all |-> inc_vec == '0);
  // R3
  fixed_inst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inc_vec[4] |-> inst_ret);
  // R3
  fixed_cyc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inc_vec[5] |-> cyc_tick);
  // R5
  arch_code_first_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (code2 == 8'hF0 || code2 == 8'hFE) |-> !inc_vec[1]);
  // R7
  running_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!frz_all && !reg_we) |=> $stable(val_flat));
  // R10
  fresh_session_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_sess |=> pend_flat == '0);
endmodule

bind frz_perf_mon pmon_chk #(.NUM(pmon_pkg::NUM_CNT), .FW(pmon_pkg::NUM_CNT*CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .cyc_tick(cyc_tick),
  .inst_ret(inst_ret), .frz_all(ctl_q[pmon_pkg::FRZ_ALL_BIT]),
  .code2(sel_q[23:16]), .start_sess(start_sess), .inc_vec(inc_vec),
  .val_flat(val_flat), .pend_flat(pend_flat)
);

// File: tb/frz_perf_mon_test.sv
module frz_perf_mon_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_we = 0;
  logic [3:0]  reg_addr = 0;
  logic [63:0] reg_wdata = 0;
  logic [63:0] reg_rdata;
  logic        cyc_tick = 0, inst_ret = 0;

  int compared = 0, mismatched = 0;

  logic [63:0] m_ctl, m_sel;
  logic [31:0] m_val [6];
  logic [31:0] m_pnd [6];

  always #4 clk = ~clk;

  frz_perf_mon uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cyc_tick(cyc_tick), .inst_ret(inst_ret)
  );

  // 0 = nothing, 1 = cycles, 2 = instructions
  function automatic int m_kind(input int n);
    logic [7:0] c;
    if (n == 4) return 2;
    if (n == 5) return 1;
    c = 8'(m_sel >> (24 - 8*n));
    if (c == 8'h02) return 2;
    if (c == 8'h1E) return 1;
    if (n == 0 && c == 8'hF0) return 1;
    if (n == 0 && c == 8'hFE) return 2;
    return 0;
  endfunction

  function automatic logic [63:0] m_read(input logic [3:0] a);
    if (a == 0) return m_ctl;
    if (a == 1) return m_sel;
    if (a >= 2 && a <= 7) return {32'h0, m_val[a-2]};
    return 64'h0;
  endfunction

  task automatic m_reset();
    m_ctl = 64'h8000_0000; m_sel = 0;
    for (int n = 0; n < 6; n++) begin m_val[n] = 0; m_pnd[n] = 0; end
  endtask

  task automatic m_update(input bit we, input logic [3:0] a, input logic [63:0] d,
                          input bit c, input bit i);
    bit start_s;
    start_s = we && a == 0 && m_ctl[31] && !d[31];
    for (int n = 0; n < 6; n++) begin
      int  k;
      bit  grp_old, grp_new, hit, cm;
      k = m_kind(n);
      grp_old = (n < 4) ? m_ctl[5] : m_ctl[4];
      grp_new = (n < 4) ? d[5] : d[4];
      hit = !m_ctl[31] && !grp_old && ((k == 1 && c) || (k == 2 && i));
      cm  = we && a == 0 && !m_ctl[31] && (d[31] || grp_old != grp_new);
      if (we && a == 4'(n + 2)) begin m_val[n] = d[31:0]; m_pnd[n] = 0; end
      else if (cm) begin m_val[n] = m_val[n] + m_pnd[n] + 32'(hit); m_pnd[n] = 0; end
      else if (start_s) m_pnd[n] = 0;
      else m_pnd[n] = m_pnd[n] + 32'(hit);
    end
    if (we && a == 0) m_ctl = d;
    if (we && a == 1) m_sel = d;
  endtask

  task automatic step(input bit we, input logic [3:0] a, input logic [63:0] d,
                      input bit c, input bit i, input string tag);
    logic [63:0] exp;
    @(negedge clk);
    reg_we = we; reg_addr = a; reg_wdata = d; cyc_tick = c; inst_ret = i;
    #1;
    exp = m_read(a);
    compared++;
    if (reg_rdata !== exp) begin
      mismatched++;
      $display("FAIL %s addr=%0d actual=%h expected=%h", tag, a, reg_rdata, exp);
    end
    m_update(we, a, d, c, i);
  endtask

  task automatic run(input int n, input string tag);
    for (int k = 0; k < n; k++)
      step(0, 4'(k % 9), 0, (k % 3) != 1, (k % 2) == 0, tag);
  endtask

  task automatic readall(input string tag);
    for (int a = 0; a < 10; a++) step(0, 4'(a), 0, 1, 1, tag);
  endtask

  initial begin
    #(8 * 150000);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset values, pulses while frozen
    readall("R1");
    // R2 unmapped address: write ignored, reads 0
    step(1, 4'd12, 64'hFFFF, 1, 1, "R2");
    readall("R2");
    // R4 basic codes: c1 inst, c2 cyc, c3 cyc, c4 inst
    step(1, 1, 64'h02_1E_1E_02, 0, 0, "R4");
    step(1, 0, 64'h0, 1, 1, "R10");
    run(25, "R7");
    step(1, 0, 64'h8000_0000, 1, 1, "R7");
    readall("R4");
    // R5 architected codes
    step(1, 1, 64'hF0_FE_F0_FE, 0, 0, "R5");
    step(1, 0, 64'h0, 0, 0, "R10");
    run(20, "R5");
    step(1, 0, 64'h8000_0000, 1, 0, "R5");
    readall("R5");
    step(1, 1, 64'hFE_55_00_1E, 0, 0, "R5");
    step(1, 0, 64'h0, 0, 0, "R3");
    run(17, "R3");
    step(1, 0, 64'h8000_0000, 0, 1, "R3");
    readall("R3");
    // R8 global and group set together
    step(1, 1, 64'h1E_02_1E_1E, 0, 0, "R8");
    step(1, 0, 64'h0, 1, 1, "R8");
    run(13, "R8");
    step(1, 0, 64'h8000_0020, 1, 1, "R8");
    readall("R8");
    // R9 group changes while running
    step(1, 0, 64'h0, 1, 1, "R9");
    run(11, "R9");
    step(1, 0, 64'h20, 1, 1, "R9");
    run(9, "R9");
    readall("R9");
    step(1, 0, 64'h10, 1, 1, "R9");
    run(7, "R9");
    step(1, 0, 64'h30, 1, 1, "R6");
    run(6, "R6");
    step(1, 0, 64'h0, 1, 1, "R9");
    run(5, "R9");
    step(1, 0, 64'h8000_0000, 1, 1, "R9");
    readall("R9");
    // R11 inert control bits
    step(1, 0, 64'hA5A5_0000_000C_0000, 1, 1, "R11");
    run(10, "R11");
    step(1, 0, 64'h800C_0000, 1, 1, "R11");
    readall("R11");
    // R12 wrap
    step(1, 7, 64'hFFFF_FFFF_FFFF_FFFE, 1, 1, "R12");
    step(1, 6, 64'hFFFF_FFFF, 1, 1, "R12");
    step(1, 0, 64'h0, 1, 1, "R12");
    run(6, "R12");
    step(1, 0, 64'h8000_0000, 1, 1, "R12");
    readall("R12");
    // R13 counter load during a session drops pending and same-cycle event
    step(1, 0, 64'h0, 1, 1, "R13");
    run(8, "R13");
    step(1, 2, 64'h1234_5678, 1, 1, "R13");
    step(1, 7, 64'h100, 1, 1, "R13");
    run(8, "R13");
    step(1, 0, 64'h8000_0000, 1, 1, "R13");
    readall("R13");
    // R10 a new session adds to committed totals
    step(1, 0, 64'h0, 1, 1, "R10");
    run(12, "R10");
    step(1, 0, 64'h8000_0010, 0, 0, "R10");
    readall("R10");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule